// File: doc/BRIEF.md
# Auxiliary UART Register Front End

This block is the register-facing half of a simplified auxiliary UART. A processor reaches it over a 32-bit word register port with separate read and write strobes, an 8-bit byte offset and a write data word. Bytes from the line side enter a circular receive FIFO through a valid/ready handshake. Each write to the data register sends one byte out on a byte strobe. Serial bit timing is not part of this block. The transmit side is treated as always drained, so its status bits are fixed.

Status words are built from the receive FIFO occupancy plus fixed constant bits. A two-bit interrupt mask selects the receive and transmit interrupt sources. The level interrupt output is registered one cycle after the state that causes it. Line control, modem control, the scratch location, the baud divisor and the SPI channels are not modelled: any offset without a decode below reads zero and ignores writes.

Top module: `auxuart_front`

## Requirements
- R1: After synchronous reset the FIFO is empty, the mask is zero, `irq` and `txValid` are low, `rxReady` is high, and offset 0x64 reads 0x30E.
- R2: A write to offset 0x44 keeps only `wrData[1:0]` as the mask (bit 0 enables receive, bit 1 enables transmit). A read of 0x44 returns 0xC0 ORed with the mask.
- R3: The receive source is pending when mask bit 0 is set and the FIFO is non-empty. The transmit source is pending whenever mask bit 1 is set. `irq` equals "any source pending" as it was one cycle earlier.
- R4: A read of offset 0x48 returns 0xC0 ORed with 0x4 if the FIFO holds data, or with 0x2 if it does not. Bit 0 is also set when no source is pending.
- R5: A read of offset 0x40 returns the byte at the read pointer in bits 7:0, with zeros above. On a non-empty FIFO it then removes that byte, so bytes come out in arrival order across the pointer wrap. On an empty FIFO the read changes no state.
- R6: An accepted byte (`rxValid` and `rxReady` both high) is stored behind the bytes already held. `rxReady` is low while the FIFO holds DEPTH bytes, and a byte offered then is not stored.
- R7: A write to offset 0x48 with `wrData[1]` set empties the FIFO. With `wrData[1]` clear, the FIFO is not changed.
- R8: Offset 0x54 reads 0x60, with bit 0 added when the FIFO is non-empty.
- R9: Offset 0x64 reads 0x30E, with bit 0 set when the FIFO is non-empty and the FIFO fill level in bits 16 and up.
- R10: Offset 0x04 always reads 1 and offset 0x60 always reads 3. Offset 0x00 reads 1 when any source is pending, and 0 otherwise.
- R11: Offsets 0x4C, 0x50, 0x58, 0x5C and 0x68, and any other offset without a decode, read zero. Writes to them change neither read values nor FIFO state.
- R12: A write to offset 0x40 makes `txValid` high for exactly the next cycle, with `txByte` equal to `wrData[7:0]`.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle `rdEn` is high |
| rxByte | input | 8 | Incoming line byte |
| rxValid | input | 1 | Incoming byte present |
| rxReady | output | 1 | FIFO can take a byte |
| txByte | output | 8 | Outgoing byte |
| txValid | output | 1 | Outgoing byte strobe |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench samples it in the same cycle it raises `rdEn`, just before the clock edge that performs any pop. FIFO and mask updates land at the edge that ends a write or push. `txValid` rises at that same edge. `irq` follows one edge later still. Interrupt checks therefore look first right after the causing edge, expecting the old level, and again after one more edge, expecting the new level. Each direct FIFO effect is checked through the status reads in the following cycle.

// File: rtl/auxuart_pkg.sv
package auxuart_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_PENDSUM  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ENABLE   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DATA     = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_INTMASK  = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_INTID    = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_LINESTAT = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_XCTRL    = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_XSTAT    = 8'h64;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PENDSUM, SEL_ENABLE, SEL_DATA, SEL_INTMASK,
    SEL_INTID, SEL_LINESTAT, SEL_XCTRL, SEL_XSTAT
  } regSelT;

  typedef struct packed {
    regSelT sel;
    logic   pop;
    logic   loadMask;
    logic   flush;
    logic   send;
  } ctrlStrobeT;
endpackage

// File: rtl/auxuart_ctrl.sv
module auxuart_ctrl
  import auxuart_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              flushBit,
  output ctrlStrobeT        strobe
);
  regSelT sel;

  always_comb begin
    unique case (addr)
      OFF_PENDSUM:  sel = SEL_PENDSUM;
      OFF_ENABLE:   sel = SEL_ENABLE;
      OFF_DATA:     sel = SEL_DATA;
      OFF_INTMASK:  sel = SEL_INTMASK;
      OFF_INTID:    sel = SEL_INTID;
      OFF_LINESTAT: sel = SEL_LINESTAT;
      OFF_XCTRL:    sel = SEL_XCTRL;
      OFF_XSTAT:    sel = SEL_XSTAT;
      default:      sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.sel      = rdEn ? sel : SEL_NONE;
    strobe.pop      = rdEn && (sel == SEL_DATA);
    strobe.loadMask = wrEn && (sel == SEL_INTMASK);
    strobe.flush    = wrEn && (sel == SEL_INTID) && flushBit;
    strobe.send     = wrEn && (sel == SEL_DATA);
  end
endmodule

// File: rtl/auxuart_datapath.sv
module auxuart_datapath
  import auxuart_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobeT        strobe,
  input  logic [1:0]        maskIn,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              irq,
  output logic [DATA_W-1:0] rdData,
  output logic [$clog2(DEPTH+1)-1:0] fifoCount,
  output logic              pendAny
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BYTE_W-1:0] store [DEPTH];
  logic [PW-1:0]     rdPtr;
  logic [CW-1:0]     count;
  logic [1:0]        intMask;
  logic [CW:0]       slotSum;
  logic [CW:0]       slotIdx;
  logic              nonEmpty, push, doPop;
  logic [1:0]        pend;

  assign nonEmpty = (count != '0);
  assign rxReady  = (count < CW'(DEPTH)) && !strobe.flush;
  assign push     = rxValid && rxReady;
  assign doPop    = strobe.pop && nonEmpty;
  assign slotSum  = (CW+1)'(rdPtr) + (CW+1)'(count);
  assign slotIdx  = (slotSum >= (CW+1)'(DEPTH)) ? slotSum - (CW+1)'(DEPTH) : slotSum;

  always_ff @(posedge clk) begin
    if (push) store[PW'(slotIdx)] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.flush) count <= '0;
      else              count <= count + CW'(push) - CW'(doPop);
      if (doPop) rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  end

  assign pend    = {intMask[1], intMask[0] && nonEmpty};
  assign pendAny = |pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      intMask <= '0;
      irq     <= 1'b0;
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      if (strobe.loadMask) intMask <= maskIn;
      irq     <= pendAny;
      txValid <= strobe.send;
      if (strobe.send) txByte <= byteIn;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.sel)
      SEL_PENDSUM:  rdData = DATA_W'(pendAny);
      SEL_ENABLE:   rdData = 32'h1;
      SEL_DATA:     rdData = DATA_W'(store[rdPtr]);
      SEL_INTMASK:  rdData = 32'hC0 | DATA_W'(intMask);
      SEL_INTID:    rdData = 32'hC0 | (nonEmpty ? 32'h4 : 32'h2) | DATA_W'(!pendAny);
      SEL_LINESTAT: rdData = 32'h60 | DATA_W'(nonEmpty);
      SEL_XCTRL:    rdData = 32'h3;
      SEL_XSTAT:    rdData = 32'h30E | DATA_W'(nonEmpty) | (DATA_W'(count) << 16);
      default:      rdData = '0;
    endcase
  end

  assign fifoCount = count;
endmodule

// File: rtl/auxuart_front.sv
module auxuart_front
  import auxuart_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              irq
);
  ctrlStrobeT strobe;
  logic [$clog2(DEPTH+1)-1:0] fifoCount;
  logic pendAny;

  auxuart_ctrl ctrl_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .flushBit(wrData[1]), .strobe(strobe)
  );

  auxuart_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .maskIn(wrData[1:0]), .byteIn(wrData[BYTE_W-1:0]),
    .rxByte(rxByte), .rxValid(rxValid), .rxReady(rxReady),
    .txByte(txByte), .txValid(txValid), .irq(irq), .rdData(rdData),
    .fifoCount(fifoCount), .pendAny(pendAny)
  );
endmodule

// File: rtl/auxuart_front_chk.sv
module auxuart_front_chk
  import auxuart_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              rxValid,
  input logic              txValid,
  input logic [BYTE_W-1:0] txByte,
  input logic              irq,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount,
  input logic              pendAny
);
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifoCount <= ($clog2(DEPTH+1))'(DEPTH));

  // R3
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(pendAny)));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == OFF_INTID && wrData[1]) |=> (fifoCount == '0));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr == OFF_DATA && fifoCount == '0 && !rxValid) |=> (fifoCount == '0));

  // R12
  tx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == OFF_DATA) |=> (txValid && txByte == $past(wrData[BYTE_W-1:0])));

  // R12
  tx_single_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && addr == OFF_DATA) |=> !txValid);
endmodule

bind auxuart_front auxuart_front_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .rxValid(rxValid), .txValid(txValid), .txByte(txByte), .irq(irq),
  .fifoCount(fifoCount), .pendAny(pendAny)
);

// File: tb/auxuart_front_tb_top.sv
module auxuart_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [7:0] rxByte = '0;
  logic rxValid = 1'b0;
  logic rxReady;
  logic [7:0] txByte;
  logic txValid;
  logic irq;

  int nRun = 0, nFail = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  auxuart_front #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rxByte(rxByte), .rxValid(rxValid), .rxReady(rxReady),
    .txByte(txByte), .txValid(txValid), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic regWrite(input logic [7:0] off, input logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; addr = off; wrData = val;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] off, output logic [31:0] val);
    @(negedge clk);
    rdEn = 1'b1; addr = off;
    #1 val = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic readChk(input logic [7:0] off, input logic [31:0] exp, input string req);
    logic [31:0] v;
    regRead(off, v);
    chkEq(req, v, exp);
  endtask

  task automatic pushByte(input logic [7:0] b, input bit expReady, input string req);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    #1 chkEq(req, {31'b0, rxReady}, {31'b0, expReady});
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic tReset();
    chkEq("R1 irq", {31'b0, irq}, 0);
    chkEq("R1 txValid", {31'b0, txValid}, 0);
    chkEq("R1 rxReady", {31'b0, rxReady}, 1);
    readChk(8'h64, 32'h30E, "R1 xstat");
    readChk(8'h44, 32'hC0, "R1 mask");
  endtask

  task automatic tMask();
    regWrite(8'h44, 32'hFFFF_FFFF);
    readChk(8'h44, 32'hC3, "R2 mask all");
    regWrite(8'h44, 32'h0000_0001);
    readChk(8'h44, 32'hC1, "R2 mask rx");
    regWrite(8'h44, 32'h0);
    readChk(8'h44, 32'hC0, "R2 mask clear");
    @(posedge clk); #1;
  endtask

  task automatic tTxInt();
    regWrite(8'h44, 32'h2);
    chkEq("R3 irq latency", {31'b0, irq}, 0);
    @(posedge clk); #1;
    chkEq("R3 tx irq", {31'b0, irq}, 1);
    readChk(8'h48, 32'hC2, "R4 id tx pending");
    readChk(8'h00, 32'h1, "R10 pend summary set");
    regWrite(8'h44, 32'h0);
    @(posedge clk); #1;
    chkEq("R3 irq cleared", {31'b0, irq}, 0);
    readChk(8'h48, 32'hC3, "R4 id none");
    readChk(8'h00, 32'h0, "R10 pend summary clear");
  endtask

  task automatic tFifoOrder();
    logic [31:0] v;
    pushByte(8'hA1, 1, "R6 ready");
    pushByte(8'hA2, 1, "R6 ready");
    pushByte(8'hA3, 1, "R6 ready");
    readChk(8'h54, 32'h61, "R8 linestat data");
    readChk(8'h64, 32'h0003_030F, "R9 xstat three");
    readChk(8'h48, 32'hC5, "R4 id rx data no pend");
    readChk(8'h40, 32'hA1, "R5 pop first");
    readChk(8'h40, 32'hA2, "R5 pop second");
    readChk(8'h40, 32'hA3, "R5 pop third");
    readChk(8'h54, 32'h60, "R8 linestat empty");
    regRead(8'h40, v);
    readChk(8'h64, 32'h30E, "R5 empty read no change");
  endtask

  task automatic tRxInt();
    regWrite(8'h44, 32'h1);
    pushByte(8'h5C, 1, "R6 ready");
    chkEq("R3 rx irq latency", {31'b0, irq}, 0);
    @(posedge clk); #1;
    chkEq("R3 rx irq", {31'b0, irq}, 1);
    readChk(8'h48, 32'hC4, "R4 id rx pending");
    readChk(8'h40, 32'h5C, "R5 pop rx");
    @(posedge clk); #1;
    chkEq("R3 rx irq clear", {31'b0, irq}, 0);
    regWrite(8'h44, 32'h0);
  endtask

  task automatic tFullWrap();
    for (int i = 0; i < DEPTH; i++) pushByte(8'(8'h10 + i), 1, "R6 ready below full");
    #1 chkEq("R6 not ready at full", {31'b0, rxReady}, 0);
    readChk(8'h64, 32'h0008_030F, "R9 xstat full");
    pushByte(8'hEE, 0, "R6 offer at full");
    readChk(8'h64, 32'h0008_030F, "R6 offer dropped");
    for (int i = 0; i < DEPTH; i++) readChk(8'h40, 32'(8'h10 + i), "R5 wrap order");
    readChk(8'h64, 32'h30E, "R9 xstat drained");
  endtask

  task automatic tFlush();
    pushByte(8'h31, 1, "R6 ready");
    pushByte(8'h32, 1, "R6 ready");
    regWrite(8'h48, 32'h1);
    readChk(8'h64, 32'h0002_030F, "R7 no flush bit");
    regWrite(8'h48, 32'h2);
    readChk(8'h64, 32'h30E, "R7 flushed");
    readChk(8'h54, 32'h60, "R7 linestat after flush");
  endtask

  task automatic tFixedAndUnused();
    readChk(8'h04, 32'h1, "R10 enable");
    readChk(8'h60, 32'h3, "R10 xctrl");
    pushByte(8'h77, 1, "R6 ready");
    regWrite(8'h5C, 32'hFFFF_FFFF);
    regWrite(8'h4C, 32'hFFFF_FFFF);
    regWrite(8'h68, 32'h1234);
    regWrite(8'h60, 32'h0);
    readChk(8'h5C, 32'h0, "R11 scratch zero");
    readChk(8'h4C, 32'h0, "R11 line ctrl zero");
    readChk(8'h50, 32'h0, "R11 modem ctrl zero");
    readChk(8'h58, 32'h0, "R11 modem stat zero");
    readChk(8'h68, 32'h0, "R11 baud zero");
    readChk(8'hF0, 32'h0, "R11 undecoded zero");
    readChk(8'h60, 32'h3, "R11 xctrl unchanged");
    readChk(8'h64, 32'h0001_030F, "R11 fifo unchanged");
    readChk(8'h40, 32'h77, "R11 byte intact");
  endtask

  task automatic tTransmit();
    regWrite(8'h40, 32'h0000_01A5);
    chkEq("R12 txValid", {31'b0, txValid}, 1);
    chkEq("R12 txByte", {24'b0, txByte}, 32'hA5);
    @(posedge clk); #1;
    chkEq("R12 txValid one cycle", {31'b0, txValid}, 0);
    readChk(8'h64, 32'h30E, "R12 no rx side effect");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    tReset();
    tMask();
    tTxInt();
    tFifoOrder();
    tRxInt();
    tFullWrap();
    tFlush();
    tFixedAndUnused();
    tTransmit();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule